// File: doc/BRIEF.md
# Multi-Setup Converter Serial Readout Controller

This block is the digital side of a multi-channel converter's three-wire serial port. A host shifts 8-bit command bytes in on `sdi` with `sclk` while `cs_n` is low. A start-conversion command makes the block walk a programmed list of channel setups and hand each one to a stub converter of fixed latency. Each 24-bit result is stored in a result buffer. When the last setup of a pass has been converted, `sdo` falls as a ready flag. The host then gives eight clocks to clear the flag and reads every result back, most significant bit first.

In single-pass mode the list is converted once, and the port goes back to command mode after the last bit has been read. In loop mode the list is converted again and again in the background while the host reads. An all-ones byte given during the flag-clearing clocks ends the loop once the remaining results have been read. A calibration command is also accepted; it runs a fixed-latency stub and leaves the port in command mode.

Top module: `mseq_serial_port`

## Requirements
- R1: After reset the port is in command mode and `sdo` is high.
- R2: A command byte is 8 bits, sampled on rising `sclk` edges, MSB first. Bit 7 = 1 with bits [2:0] = 000 starts conversions. Bits [6:3] carry a channel or setup field. A byte with bit 7 = 0 is ignored: `sdo` stays high and nothing is converted.
- R3: With `cfg_multi` = 1, one pass converts `cfg_depth` + 1 setups (value 9 gives 10 setups, 0 gives 1).
- R4: Setups are converted in list order, and results are read back in that same order. Setup i takes its channel from `cfg_chan_list[4*i+3:4*i]`, and one channel may appear in several setups. A result is {4'hA, channel[3:0], setup index[7:0], pass number[7:0]}, where the pass number counts from 0 at the start command.
- R5: `sdo` stays high while a pass is converting and falls once the last setup of that pass has been converted, which is about (setups × CONV_LAT) clocks after the command.
- R6: While the flag is low the host gives 8 clearing clocks, during which `sdo` stays low. After them each result is shifted out as 24 bits, MSB first, one bit per `sclk` cycle. Bits change after falling edges and are valid at the next rising edge.
- R7: With `cfg_loop` = 0, after the last bit of the last result `sdo` returns high, no further flag appears, and the port accepts a new command.
- R8: With `cfg_loop` = 1, the next pass is converted during readout. Its flag falls when that pass completes, and its results carry a pass number one higher.
- R9: In loop mode, the byte 8'hFF shifted in during the clearing clocks ends the loop. The current pass is still read out in full, then the port returns to command mode and no further flag appears. Any other clearing byte keeps the loop running.
- R10: With `cfg_multi` = 0, a start command converts exactly one result. Its channel is command bits [6:3], and `cfg_depth` is ignored.
- R11: A byte with bit 7 = 1 and bits [2:0] ≠ 000 starts a calibration stub. The port stays in command mode, and `sdo` falls CAL_LAT clocks later. The next complete command byte raises `sdo` again.
- R12: Raising `cs_n` discards a partly shifted byte: the bit counter restarts at the next falling of `cs_n`.
- R13: `sclk` activity while a pass is converting and the flag is still high is ignored and does not disturb the later readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| sdo | output | 1 | Ready flag or result data out |
| cfg_depth | input | 4 | Number of setups per pass, minus one |
| cfg_multi | input | 1 | 1: walk the setup list; 0: channel comes from the command byte |
| cfg_loop | input | 1 | 1: convert continuously; 0: one pass |
| cfg_chan_list | input | 64 | Physical channel of each of the 16 setups, 4 bits each |

## Verification
The bench aims at the points where a port like this usually breaks. One is the flag timing for the longest list with a repeated channel: a design that raises the flag after the first setup, or counts depth without the plus one, would show a flag far too early or a short readout. Another is stray clocks sent before the flag and partial bytes cut off by `cs_n`: a design that counts them would shift the command or readout alignment and return garbled words. The loop-exit byte is sent on the second pass and checked against later flags; a design that stops at once, or keeps converting after the exit, would either drop results or drop the flag again. A calibration followed straight away by a conversion shows whether the port wrongly leaves command mode, or wrongly keeps `sdo` low, after calibrating.

// File: rtl/mseq_sport_pkg.sv
package mseq_sport_pkg;
  localparam int CMD_W   = 8;
  localparam int RES_W   = 24;
  localparam int CH_W    = 4;
  localparam int DEPTH_W = 4;
  localparam int NSETUP  = 1 << DEPTH_W;
  localparam int LEN_W   = DEPTH_W + 1;
  localparam int CNT_W   = $clog2(RES_W);
  localparam int PASS_W  = 8;

  typedef enum logic [1:0] {
    PS_CMD  = 2'd0,
    PS_WAIT = 2'd1,
    PS_READ = 2'd2
  } port_st_e;

  // Stub converter result word: marker, channel, setup slot, pass number
  function automatic logic [RES_W-1:0] make_result(
    input logic [CH_W-1:0]    ch,
    input logic [DEPTH_W-1:0] slot,
    input logic [PASS_W-1:0]  pass
  );
    return {4'hA, ch, 8'(slot), pass};
  endfunction
endpackage

// File: rtl/mseq_sync.sv
module mseq_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/mseq_conv_seq.sv
module mseq_conv_seq import mseq_sport_pkg::*; #(
  parameter int CONV_LAT = 400,
  parameter int CAL_LAT  = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     cal_start,
  input  logic                     abort,
  input  logic                     loop_en,
  input  logic                     multi,
  input  logic [LEN_W-1:0]         pass_len,
  input  logic [CH_W-1:0]          cmd_chan,
  input  logic [NSETUP*CH_W-1:0]   chan_list,
  output logic                     wr_en,
  output logic [DEPTH_W-1:0]       wr_idx,
  output logic [RES_W-1:0]         wr_data,
  output logic                     pass_done,
  output logic                     cal_busy,
  output logic                     cal_done
);
  localparam int LAT_W = $clog2(CONV_LAT + 1);
  localparam int CAL_W = $clog2(CAL_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_RELOAD = LAT_W'(CONV_LAT - 1);
  localparam logic [CAL_W-1:0] CAL_RELOAD = CAL_W'(CAL_LAT - 1);

  logic               run_q, run_d;
  logic [DEPTH_W-1:0] slot_q, slot_d;
  logic [PASS_W-1:0]  pass_q, pass_d;
  logic [LAT_W-1:0]   tmr_q, tmr_d;
  logic               cbusy_q, cbusy_d;
  logic [CAL_W-1:0]   ctmr_q, ctmr_d;
  logic               last_slot;
  logic [CH_W-1:0]    chan;

  assign last_slot = ({1'b0, slot_q} == (pass_len - LEN_W'(1)));
  assign chan      = multi ? chan_list[int'(slot_q)*CH_W +: CH_W] : cmd_chan;

  always_comb begin
    run_d     = run_q;
    slot_d    = slot_q;
    pass_d    = pass_q;
    tmr_d     = tmr_q;
    wr_en     = 1'b0;
    pass_done = 1'b0;
    if (start) begin
      run_d  = 1'b1;
      slot_d = '0;
      pass_d = '0;
      tmr_d  = LAT_RELOAD;
    end else if (run_q) begin
      if (abort) begin
        run_d = 1'b0;
      end else if (tmr_q == '0) begin
        wr_en = 1'b1;
        tmr_d = LAT_RELOAD;
        if (last_slot) begin
          pass_done = 1'b1;
          slot_d    = '0;
          if (loop_en) pass_d = pass_q + PASS_W'(1);
          else         run_d  = 1'b0;
        end else begin
          slot_d = slot_q + DEPTH_W'(1);
        end
      end else begin
        tmr_d = tmr_q - LAT_W'(1);
      end
    end
  end

  always_comb begin
    cbusy_d  = cbusy_q;
    ctmr_d   = ctmr_q;
    cal_done = 1'b0;
    if (cal_start) begin
      cbusy_d = 1'b1;
      ctmr_d  = CAL_RELOAD;
    end else if (cbusy_q) begin
      if (ctmr_q == '0) begin
        cbusy_d  = 1'b0;
        cal_done = 1'b1;
      end else begin
        ctmr_d = ctmr_q - CAL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      slot_q  <= '0;
      pass_q  <= '0;
      tmr_q   <= '0;
      cbusy_q <= 1'b0;
      ctmr_q  <= '0;
    end else begin
      run_q   <= run_d;
      slot_q  <= slot_d;
      pass_q  <= pass_d;
      tmr_q   <= tmr_d;
      cbusy_q <= cbusy_d;
      ctmr_q  <= ctmr_d;
    end
  end

  assign wr_idx   = slot_q;
  assign wr_data  = make_result(chan, slot_q, pass_q);
  assign cal_busy = cbusy_q;
endmodule

// File: rtl/mseq_res_buf.sv
module mseq_res_buf import mseq_sport_pkg::*; #(
  parameter int DEPTH = NSETUP,
  parameter int W     = RES_W
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == ($clog2(DEPTH))'(g));
    always_ff @(posedge clk) begin
      if (hit) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mseq_serial_port.sv
module mseq_serial_port import mseq_sport_pkg::*; #(
  parameter int CONV_LAT = 400,
  parameter int CAL_LAT  = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  input  logic [DEPTH_W-1:0]     cfg_depth,
  input  logic                   cfg_multi,
  input  logic                   cfg_loop,
  input  logic [NSETUP*CH_W-1:0] cfg_chan_list
);
  localparam logic [CNT_W-1:0] LAST_CMD_BIT = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_RES_BIT = CNT_W'(RES_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_a_q, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_int <= rst_a_q;
    end
  end

  logic [2:0] pins_s;
  logic       cs_s, sclk_s, sdi_s, sclk_d;
  mseq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_int), .d({cs_n, sclk, sdi}), .q(pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) sclk_d <= 1'b0;
    else          sclk_d <= sclk_s;
  end

  logic rise, fall;
  assign rise = !cs_s &&  sclk_s && !sclk_d;
  assign fall = !cs_s && !sclk_s &&  sclk_d;

  port_st_e           st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CMD_W-1:0]   byte_q, byte_d, byte_in;
  logic [DEPTH_W-1:0] rd_idx_q, rd_idx_d;
  logic               sdo_q, sdo_d;
  logic               pend_q, pend_d;
  logic               exit_q, exit_d;
  logic               calf_q, calf_d;
  logic               loop_q, loop_d;
  logic               multi_q, multi_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [CH_W-1:0]    chan_q, chan_d;
  logic               start, cal_start;

  logic               wr_en, pass_done, cal_busy, cal_done;
  logic [DEPTH_W-1:0] wr_idx;
  logic [RES_W-1:0]   wr_data, rd_data;
  logic               last_res;

  assign byte_in  = {byte_q[CMD_W-2:0], sdi_s};
  assign last_res = ({1'b0, rd_idx_q} == (len_q - LEN_W'(1)));

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    byte_d    = byte_q;
    rd_idx_d  = rd_idx_q;
    sdo_d     = sdo_q;
    pend_d    = pend_q;
    exit_d    = exit_q;
    calf_d    = calf_q;
    loop_d    = loop_q;
    multi_d   = multi_q;
    len_d     = len_q;
    chan_d    = chan_q;
    start     = 1'b0;
    cal_start = 1'b0;
    if (cal_done) calf_d = 1'b1;
    if (cs_s) begin
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PS_CMD: if (rise) begin
          byte_d = byte_in;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_CMD_BIT) begin
            cnt_d  = '0;
            calf_d = 1'b0;
            if (byte_in[CMD_W-1] && !cal_busy) begin
              if (byte_in[2:0] == 3'b000) begin
                start   = 1'b1;
                st_d    = PS_WAIT;
                pend_d  = 1'b0;
                exit_d  = 1'b0;
                loop_d  = cfg_loop;
                multi_d = cfg_multi;
                len_d   = cfg_multi ? ({1'b0, cfg_depth} + LEN_W'(1)) : LEN_W'(1);
                chan_d  = byte_in[6:3];
              end else begin
                cal_start = 1'b1;
              end
            end
          end
        end
        PS_WAIT: if (rise && pend_q) begin
          byte_d = byte_in;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_CMD_BIT) begin
            cnt_d    = '0;
            pend_d   = 1'b0;
            exit_d   = loop_q && (byte_in == '1);
            st_d     = PS_READ;
            rd_idx_d = '0;
            sdo_d    = 1'b0;
          end
        end
        PS_READ: begin
          if (fall) sdo_d = rd_data[LAST_RES_BIT - cnt_q];
          if (rise) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_RES_BIT) begin
              cnt_d = '0;
              if (last_res) begin
                if (!loop_q || exit_q) begin
                  st_d   = PS_CMD;
                  exit_d = 1'b0;
                end else begin
                  st_d = PS_WAIT;
                end
              end else begin
                rd_idx_d = rd_idx_q + DEPTH_W'(1);
              end
            end
          end
        end
        default: st_d = PS_CMD;
      endcase
    end
    if (pass_done) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_q     <= PS_CMD;
      cnt_q    <= '0;
      byte_q   <= '0;
      rd_idx_q <= '0;
      sdo_q    <= 1'b0;
      pend_q   <= 1'b0;
      exit_q   <= 1'b0;
      calf_q   <= 1'b0;
      loop_q   <= 1'b0;
      multi_q  <= 1'b0;
      len_q    <= LEN_W'(1);
      chan_q   <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      byte_q   <= byte_d;
      rd_idx_q <= rd_idx_d;
      sdo_q    <= sdo_d;
      pend_q   <= pend_d;
      exit_q   <= exit_d;
      calf_q   <= calf_d;
      loop_q   <= loop_d;
      multi_q  <= multi_d;
      len_q    <= len_d;
      chan_q   <= chan_d;
    end
  end

  always_comb begin
    unique case (st_q)
      PS_WAIT: sdo = !pend_q;
      PS_READ: sdo = sdo_q;
      default: sdo = !calf_q;
    endcase
  end

  mseq_conv_seq #(.CONV_LAT(CONV_LAT), .CAL_LAT(CAL_LAT)) u_seq (
    .clk(clk), .rst_n(rst_int),
    .start(start), .cal_start(cal_start), .abort(exit_q),
    .loop_en(loop_q), .multi(multi_q), .pass_len(len_q),
    .cmd_chan(chan_q), .chan_list(cfg_chan_list),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pass_done(pass_done), .cal_busy(cal_busy), .cal_done(cal_done)
  );

  mseq_res_buf #(.DEPTH(NSETUP), .W(RES_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/mseq_serial_port_chk.sv
module mseq_serial_port_chk import mseq_sport_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input port_st_e           st,
  input logic               pend,
  input logic               exit_q,
  input logic               loop_q,
  input logic [LEN_W-1:0]   len_q,
  input logic               wr_en,
  input logic [DEPTH_W-1:0] wr_idx,
  input logic               pass_done,
  input logic               cal_busy,
  input logic               cs_s,
  input logic [CNT_W-1:0]   cnt
);
  AST_READ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_READ && $past(st) == PS_WAIT) |-> $past(pend)); // R6

  AST_WRITE_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_idx} < len_q)); // R3

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (wr_en && ({1'b0, wr_idx} == len_q - LEN_W'(1)))); // R5

  AST_LOOP_LEAVES_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_CMD && $past(st) == PS_READ) |-> ($past(exit_q) || !$past(loop_q))); // R9

  AST_CAL_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (st == PS_CMD)); // R11

  AST_CS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0)); // R12
endmodule

bind mseq_serial_port mseq_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_int), .st(st_q), .pend(pend_q), .exit_q(exit_q),
  .loop_q(loop_q), .len_q(len_q), .wr_en(wr_en), .wr_idx(wr_idx),
  .pass_done(pass_done), .cal_busy(cal_busy), .cs_s(cs_s), .cnt(cnt_q)
);

// File: tb/mseq_serial_port_tb.sv
module mseq_serial_port_tb;
  import mseq_sport_pkg::*;

  localparam int LAT  = 400;
  localparam int CLAT = 100;
  localparam int H    = 4;

  logic clk, rst_n, cs_n, sclk, sdi, sdo;
  logic [3:0]  cfg_depth;
  logic        cfg_multi, cfg_loop;
  logic [63:0] cfg_chan_list;
  int cyc, errors, checks;
  logic [3:0] exp_ch [16];

  mseq_serial_port #(.CONV_LAT(LAT), .CAL_LAT(CLAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .cfg_depth(cfg_depth), .cfg_multi(cfg_multi), .cfg_loop(cfg_loop),
    .cfg_chan_list(cfg_chan_list)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, output logic o);
    sdi = b; sclk = 1'b0;
    tick(H);
    o = sdo;
    sclk = 1'b1;
    tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic o;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], o);
  endtask

  task automatic wait_flag(input int maxc, output int dt);
    int t0;
    t0 = cyc;
    while (sdo !== 1'b0 && (cyc - t0) < maxc) tick(1);
    dt = cyc - t0;
  endtask

  task automatic stay_high(input int n, input string req);
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (sdo !== 1'b1) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  task automatic clear_flag(input logic [7:0] b, input string req);
    logic o;
    int highs;
    highs = 0;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(b[i], o);
      if (o !== 1'b0) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  task automatic read_results(input int n, input int pass, input string req);
    logic [23:0] v, e;
    logic o;
    for (int r = 0; r < n; r++) begin
      for (int b = 23; b >= 0; b--) begin
        xfer_bit(1'b0, o);
        v[b] = o;
      end
      e = {4'hA, exp_ch[r], 8'(r), 8'(pass)};
      chk(v === e, req, {8'h0, v}, {8'h0, e});
    end
  endtask

  task automatic load_list();
    for (int i = 0; i < 16; i++) cfg_chan_list[i*4 +: 4] = exp_ch[i];
  endtask

  task automatic t_reset();
    tick(6);
    chk(sdo === 1'b1, "R1 sdo after reset", {31'h0, sdo}, 1);
  endtask

  task automatic t_ignored();
    cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'd0;
    send_byte(8'h05);
    stay_high(2 * LAT, "R2 byte with bit7=0 ignored");
  endtask

  task automatic t_ten_setups();
    int dt, t0;
    logic o;
    logic [3:0] lst [10] = '{6, 1, 6, 2, 6, 3, 6, 4, 6, 5};
    for (int i = 0; i < 16; i++) exp_ch[i] = (i < 10) ? lst[i] : 4'hF;
    load_list();
    cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'd9;
    send_byte(8'h80);
    t0 = cyc;
    tick(100);
    for (int i = 0; i < 8; i++) xfer_bit(1'b1, o); // R13 stray clocks
    wait_flag(12 * LAT, dt);
    dt = cyc - t0;
    chk(dt >= 10 * LAT - 20 && dt <= 10 * LAT + 20, "R5 R3 flag timing for 10 setups", dt, 10 * LAT);
    clear_flag(8'h00, "R6 flag held during clearing clocks");
    read_results(10, 0, "R4 R6 R13 ten-setup readout");
    tick(6);
    chk(sdo === 1'b1, "R7 sdo high after single pass", {31'h0, sdo}, 1);
    stay_high(12 * LAT, "R7 no further flag in single pass");
  endtask

  task automatic t_depth_zero();
    int dt;
    exp_ch[0] = 4'd9;
    load_list();
    cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'd0;
    send_byte(8'h80);
    wait_flag(3 * LAT, dt);
    chk(dt <= LAT + 20, "R3 depth 0 gives one setup", dt, LAT);
    clear_flag(8'h55, "R6 clearing byte content ignored in single pass");
    read_results(1, 0, "R3 depth 0 result");
    tick(6);
    chk(sdo === 1'b1, "R7 back to command mode", {31'h0, sdo}, 1);
  endtask

  task automatic t_cmd_channel();
    int dt;
    cfg_multi = 1'b0; cfg_loop = 1'b0; cfg_depth = 4'd5;
    send_byte(8'hB8);
    wait_flag(8 * LAT, dt);
    chk(dt <= LAT + 20, "R10 one conversion, depth ignored", dt, LAT);
    clear_flag(8'h00, "R10 flag");
    exp_ch[0] = 4'd7;
    read_results(1, 0, "R10 channel from command bits");
    tick(6);
    chk(sdo === 1'b1, "R10 single result ends readout", {31'h0, sdo}, 1);
  endtask

  task automatic t_loop();
    int dt;
    logic [3:0] lst [4] = '{6, 1, 6, 2};
    for (int i = 0; i < 16; i++) exp_ch[i] = (i < 4) ? lst[i] : 4'h0;
    load_list();
    cfg_multi = 1'b1; cfg_loop = 1'b1; cfg_depth = 4'd3;
    send_byte(8'h80);
    wait_flag(6 * LAT, dt);
    chk(dt >= 4 * LAT - 20 && dt <= 4 * LAT + 20, "R8 first loop flag", dt, 4 * LAT);
    clear_flag(8'h00, "R8 clear keeps looping");
    read_results(4, 0, "R8 loop pass 0");
    tick(6);
    chk(sdo === 1'b1, "R8 flag high until next pass done", {31'h0, sdo}, 1);
    wait_flag(6 * LAT, dt);
    chk(sdo === 1'b0, "R8 background pass raises flag", {31'h0, sdo}, 0);
    clear_flag(8'hFF, "R9 exit byte during clearing");
    read_results(4, 1, "R9 R8 pass 1 read in full after exit");
    tick(6);
    chk(sdo === 1'b1, "R9 command mode after exit", {31'h0, sdo}, 1);
    stay_high(6 * LAT, "R9 no flag after exit");
  endtask

  task automatic t_cal();
    int dt, t0;
    cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'd0;
    exp_ch[0] = 4'd3;
    load_list();
    send_byte(8'hAD);
    t0 = cyc;
    wait_flag(3 * CLAT, dt);
    dt = cyc - t0;
    chk(dt >= CLAT - 20 && dt <= CLAT + 20, "R11 calibration flag time", dt, CLAT);
    send_byte(8'h80);
    tick(6);
    chk(sdo === 1'b1, "R11 next command raises sdo", {31'h0, sdo}, 1);
    wait_flag(3 * LAT, dt);
    chk(dt <= LAT + 20, "R11 port stayed in command mode", dt, LAT);
    clear_flag(8'h00, "R11 flag after calibration");
    read_results(1, 0, "R11 conversion after calibration");
  endtask

  task automatic t_cs_reset();
    int dt;
    logic o;
    cfg_multi = 1'b0; cfg_loop = 1'b0;
    tick(6);
    for (int i = 0; i < 3; i++) xfer_bit(1'b1, o);
    cs_n = 1'b1;
    tick(10);
    cs_n = 1'b0;
    tick(6);
    send_byte(8'hB8);
    wait_flag(3 * LAT, dt);
    chk(sdo === 1'b0, "R12 realigned command starts conversion", {31'h0, sdo}, 0);
    clear_flag(8'h00, "R12 flag");
    exp_ch[0] = 4'd7;
    read_results(1, 0, "R12 result after cs_n abort");
  endtask

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    cfg_depth = '0; cfg_multi = 1'b0; cfg_loop = 1'b0; cfg_chan_list = '0;
    for (int i = 0; i < 16; i++) exp_ch[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    cs_n = 1'b0;
    tick(4);
    t_ignored();
    t_ten_setups();
    t_depth_zero();
    t_cmd_channel();
    t_loop();
    t_cal();
    t_cs_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule